// File: doc/BRIEF.md
# Packed Halfword Fractional Multiply-Accumulate

This block multiplies two 32-bit words lane by lane, treating each word as a pair of 16-bit halfwords. Each lane forms a full-precision product and narrows it back to 16 bits as a fixed-point fraction. Narrowing can truncate or round. An optional per-lane accumulator halfword can then be added to or subtracted from the narrowed value, and the result can clamp to the range of its type instead of wrapping. A separate wide mode returns the untouched 32-bit product of the two low halfwords.

Operands enter and results leave over valid/ready streams, and the block holds at most two operations in flight. An input beat transfers on a rising edge where `in_valid` and `in_ready` are both high. An output beat transfers on a rising edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the result and `out_valid` hold. The front stage keeps accepting until both stages are full. The mode pins (`sgn_sel`, `acc_sel`, `rnd_en`, `sat_en`, `wide_en`) and `acc_in` travel with the operand beat and are sampled on the same edge.

Top module: `pkd_frac_mac`

## Requirements
- R1: In fractional mode with `sgn_sel`=0 (signed times signed; code 3 behaves the same), each 16-bit lane returns bits [15:0] of the signed 32-bit product shifted arithmetically right by 15. Lane 0 is bits [15:0] and lane 1 is bits [31:16]. With rounding off, 0x0180 times 0x0180 gives 0x0004.
- R2: With `rnd_en`=1, 2^(s-1) is added to the product before the right shift by s. For example, 0x0180 times 0x0180 in signed mode gives 0x0005.
- R3: With `sgn_sel`=1 (unsigned times unsigned), both halfwords are unsigned, the shift is 16 bits, and the lane value is treated as unsigned, range 0 to 0xFFFF.
- R4: With `sgn_sel`=2 (mixed), the `op_a` halfword is unsigned and the `op_b` halfword is signed. The shift is 15 and the lane value is signed. For example, 0xC000 times 0xC000 gives 0xA000.
- R5: `acc_sel`=1 adds the matching `acc_in` halfword to the narrowed lane value, and `acc_sel`=2 subtracts it. Codes 0 and 3 leave the value unchanged. The halfword is taken as unsigned in mode 1 and as signed otherwise.
- R6: With `sat_en`=1, the lane value after accumulation clamps to the type range: [-0x8000, 0x7FFF] when signed, [0, 0xFFFF] when unsigned. With `sat_en`=0 it wraps to 16 bits. For example, signed 0x8000 times 0x8000 gives 0x7FFF with clamping and 0x8000 without.
- R7: With `wide_en`=1, `result` is the full 32-bit product of the low halfwords under the selected signedness. `acc_in`, `acc_sel`, `rnd_en` and `sat_en` have no effect.
- R8: A beat accepted on edge N with the output stage empty drives `out_valid` high after edge N+1. Its result is present at that point.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `result` hold. `in_ready` is low exactly when two operations are in flight and `out_ready` is low.
- R10: While `rst_n` is low, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand beat present |
| in_ready | output | 1 | Block can take an operand beat |
| op_a | input | 32 | First packed operand |
| op_b | input | 32 | Second packed operand |
| acc_in | input | 32 | Packed accumulator halfwords |
| sgn_sel | input | 2 | 0 signed, 1 unsigned, 2 unsigned A times signed B, 3 as 0 |
| acc_sel | input | 2 | 0 none, 1 add, 2 subtract, 3 none |
| rnd_en | input | 1 | Round instead of truncate |
| sat_en | input | 1 | Clamp instead of wrap |
| wide_en | input | 1 | Return the 32-bit low-halfword product |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result beat |
| result | output | 32 | Packed result or wide product |

## Verification
The assertions assume that the consumer drives `out_ready` freely and that operand and mode pins matter only on edges where a beat is accepted. A shadow queue in the checker records the accepted beats and pairs each one with the result that leaves the block. The stimulus holds each beat steady until it is taken. It mixes bursts, gaps and long back-pressure windows so that both stages fill and drain. Every beat is compared against a behavioural model in the bench. Operand halfwords are drawn from the lane extremes (0x8000, 0x7FFF, 0xFFFF, 0) as well as random values, so that clamping and wrapping both occur.

// File: rtl/pkd_frac_mac_pkg.sv
package pkd_frac_mac_pkg;

  typedef enum logic [1:0] {
    SGN_SS  = 2'd0,
    SGN_UU  = 2'd1,
    SGN_US  = 2'd2,
    SGN_RSV = 2'd3
  } sgn_mode_e;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_ADD  = 2'd1,
    ACC_SUB  = 2'd2,
    ACC_RSV  = 2'd3
  } acc_mode_e;

  typedef struct packed {
    sgn_mode_e sgn;
    acc_mode_e acc;
    logic      rnd;
    logic      sat;
    logic      wide;
  } op_ctl_t;

endpackage

// File: rtl/pfm_pipe_ctl.sv
module pfm_pipe_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic out_ready,
  output logic s1_load,
  output logic s2_load,
  output logic out_valid
);
  logic v1_q, v2_q;
  logic s1_open, s2_open;

  // A stage may load when it is empty or when its contents move on.
  assign s2_open   = !v2_q || out_ready;
  assign s1_open   = !v1_q || s2_open;
  assign in_ready  = s1_open;
  assign s1_load   = in_valid && s1_open;
  assign s2_load   = v1_q && s2_open;
  assign out_valid = v2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      if (s1_open) v1_q <= in_valid;
      if (s2_open) v2_q <= v1_q;
    end
  end
endmodule

// File: rtl/pfm_lane_mul.sv
module pfm_lane_mul
  import pkd_frac_mac_pkg::*;
#(
  parameter int LANE_W = 16
) (
  input  logic [LANE_W-1:0]          a_i,
  input  logic [LANE_W-1:0]          b_i,
  input  sgn_mode_e                  sgn_i,
  output logic signed [2*LANE_W+1:0] prod_o
);
  logic                a_sx, b_sx;
  logic signed [LANE_W:0] a_ext, b_ext;

  always_comb begin
    a_sx   = (sgn_i == SGN_SS) || (sgn_i == SGN_RSV);
    b_sx   = (sgn_i != SGN_UU);
    a_ext  = {a_sx & a_i[LANE_W-1], a_i};
    b_ext  = {b_sx & b_i[LANE_W-1], b_i};
    prod_o = a_ext * b_ext;
  end
endmodule

// File: rtl/pfm_lane_post.sv
module pfm_lane_post
  import pkd_frac_mac_pkg::*;
#(
  parameter int LANE_W = 16
) (
  input  logic signed [2*LANE_W+1:0] prod_i,
  input  logic [LANE_W-1:0]          acc_i,
  input  sgn_mode_e                  sgn_i,
  input  acc_mode_e                  accm_i,
  input  logic                       rnd_i,
  input  logic                       sat_i,
  output logic [LANE_W-1:0]          res_o
);
  localparam int PW = 2*LANE_W + 2;
  localparam int IW = PW + 2;
  localparam logic signed [IW-1:0] RND_S = IW'(1) << (LANE_W-2);
  localparam logic signed [IW-1:0] RND_U = IW'(1) << (LANE_W-1);
  localparam logic signed [IW-1:0] S_MAX = (IW'(1) << (LANE_W-1)) - IW'(1);
  localparam logic signed [IW-1:0] S_MIN = -(IW'(1) << (LANE_W-1));
  localparam logic signed [IW-1:0] U_MAX = (IW'(1) << LANE_W) - IW'(1);
  localparam logic signed [IW-1:0] U_MIN = '0;

  logic                 uns;
  logic signed [IW-1:0] prod_x, shifted, acc_x, sum, lim_hi, lim_lo;

  always_comb begin
    uns    = (sgn_i == SGN_UU);
    prod_x = {{2{prod_i[PW-1]}}, prod_i};
    if (rnd_i) prod_x = prod_x + (uns ? RND_U : RND_S);
    shifted = uns ? (prod_x >>> LANE_W) : (prod_x >>> (LANE_W-1));
    acc_x   = uns ? {{(IW-LANE_W){1'b0}}, acc_i}
                  : {{(IW-LANE_W){acc_i[LANE_W-1]}}, acc_i};
    case (accm_i)
      ACC_ADD: sum = shifted + acc_x;
      ACC_SUB: sum = shifted - acc_x;
      default: sum = shifted;
    endcase
    lim_hi = uns ? U_MAX : S_MAX;
    lim_lo = uns ? U_MIN : S_MIN;
    if (sat_i && (sum > lim_hi))      res_o = lim_hi[LANE_W-1:0];
    else if (sat_i && (sum < lim_lo)) res_o = lim_lo[LANE_W-1:0];
    else                              res_o = sum[LANE_W-1:0];
  end
endmodule

// File: rtl/pkd_frac_mac.sv
module pkd_frac_mac
  import pkd_frac_mac_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [LANE_W*LANES-1:0]  op_a,
  input  logic [LANE_W*LANES-1:0]  op_b,
  input  logic [LANE_W*LANES-1:0]  acc_in,
  input  logic [1:0]               sgn_sel,
  input  logic [1:0]               acc_sel,
  input  logic                     rnd_en,
  input  logic                     sat_en,
  input  logic                     wide_en,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [LANE_W*LANES-1:0]  result
);
  localparam int DATA_W = LANE_W * LANES;
  localparam int PW     = 2*LANE_W + 2;

  logic s1_load, s2_load;

  pfm_pipe_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_ready (out_ready),
    .s1_load   (s1_load),
    .s2_load   (s2_load),
    .out_valid (out_valid)
  );

  op_ctl_t ctl_d, ctl_q;
  always_comb begin
    ctl_d.sgn  = sgn_mode_e'(sgn_sel);
    ctl_d.acc  = acc_mode_e'(acc_sel);
    ctl_d.rnd  = rnd_en;
    ctl_d.sat  = sat_en;
    ctl_d.wide = wide_en;
  end

  logic signed [PW-1:0] prod_d [LANES];
  logic signed [PW-1:0] prod_q [LANES];
  logic [DATA_W-1:0]    acc_q;
  logic [DATA_W-1:0]    frac_word, wide_word, result_d;

  // Stage 1: per-lane multiply, registered at full precision.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    pfm_lane_mul #(.LANE_W(LANE_W)) u_mul (
      .a_i    (op_a[l*LANE_W +: LANE_W]),
      .b_i    (op_b[l*LANE_W +: LANE_W]),
      .sgn_i  (ctl_d.sgn),
      .prod_o (prod_d[l])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       prod_q[l] <= '0;
      else if (s1_load) prod_q[l] <= prod_d[l];
    end

    // Stage 2 combinational: narrow, accumulate, clamp.
    pfm_lane_post #(.LANE_W(LANE_W)) u_post (
      .prod_i (prod_q[l]),
      .acc_i  (acc_q[l*LANE_W +: LANE_W]),
      .sgn_i  (ctl_q.sgn),
      .accm_i (ctl_q.acc),
      .rnd_i  (ctl_q.rnd),
      .sat_i  (ctl_q.sat),
      .res_o  (frac_word[l*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ctl_q <= '0;
    end else if (s1_load) begin
      acc_q <= acc_in;
      ctl_q <= ctl_d;
    end
  end

  assign wide_word = DATA_W'(prod_q[0][2*LANE_W-1:0]);
  assign result_d  = ctl_q.wide ? wide_word : frac_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       result <= '0;
    else if (s2_load) result <= result_d;
  end
endmodule

// File: rtl/pkd_frac_mac_chk.sv
module pkd_frac_mac_chk #(
  parameter int LANE_W = 16,
  parameter int LANES  = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [LANE_W*LANES-1:0] op_a,
  input logic [LANE_W*LANES-1:0] op_b,
  input logic [1:0]              sgn_sel,
  input logic [1:0]              acc_sel,
  input logic                    wide_en,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [LANE_W*LANES-1:0] result
);
  localparam int DATA_W = LANE_W * LANES;

  logic [DATA_W-1:0] sh_a [2];
  logic [DATA_W-1:0] sh_b [2];
  logic [1:0]        sh_sgn [2];
  logic [1:0]        sh_acc [2];
  logic              sh_wide [2];
  logic              wr_p, rd_p;
  logic [1:0]        occ;
  logic              push, pop;

  assign push = in_valid && in_ready;
  assign pop  = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_p <= 1'b0;
      rd_p <= 1'b0;
      occ  <= 2'd0;
    end else begin
      if (push) begin
        sh_a[wr_p]    <= op_a;
        sh_b[wr_p]    <= op_b;
        sh_sgn[wr_p]  <= sgn_sel;
        sh_acc[wr_p]  <= acc_sel;
        sh_wide[wr_p] <= wide_en;
        wr_p          <= !wr_p;
      end
      if (pop) rd_p <= !rd_p;
      occ <= occ + {1'b0, push} - {1'b0, pop};
    end
  end

  assert_reset_idle_R10: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && in_ready));

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(result)));

  assert_full_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == 2'd2 && !out_ready) |-> !in_ready);

  assert_room_accepts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (occ < 2'd2) |-> in_ready);

  assert_two_stage_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready, 2));

  assert_zero_operand_lane_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && occ != 2'd0 && sh_sgn[rd_p] == 2'd0 && !sh_wide[rd_p] &&
     sh_acc[rd_p] == 2'd0 && sh_a[rd_p][LANE_W-1:0] == '0)
    |-> (result[LANE_W-1:0] == '0));

  assert_wide_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && occ != 2'd0 && sh_wide[rd_p] &&
     (sh_a[rd_p][LANE_W-1:0] == '0 || sh_b[rd_p][LANE_W-1:0] == '0))
    |-> (result == '0));
endmodule

bind pkd_frac_mac pkd_frac_mac_chk #(.LANE_W(LANE_W), .LANES(LANES)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .op_a      (op_a),
  .op_b      (op_b),
  .sgn_sel   (sgn_sel),
  .acc_sel   (acc_sel),
  .wide_en   (wide_en),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .result    (result)
);

// File: tb/pkd_frac_mac_tb_top.sv
module pkd_frac_mac_tb_top;

  typedef struct packed {
    logic [31:0] a, b, c;
    logic [1:0]  sm, am;
    logic        rnd, sat, wide;
  } vec_t;

  localparam int NRAND = 400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b0;
  logic        in_ready, out_valid;
  logic [31:0] op_a = '0, op_b = '0, acc_in = '0, result;
  logic [1:0]  sgn_sel = '0, acc_sel = '0;
  logic        rnd_en = 1'b0, sat_en = 1'b0, wide_en = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  pkd_frac_mac dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .acc_in(acc_in), .sgn_sel(sgn_sel),
    .acc_sel(acc_sel), .rnd_en(rnd_en), .sat_en(sat_en), .wide_en(wide_en),
    .out_valid(out_valid), .out_ready(out_ready), .result(result)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input vec_t v);
    longint pa, pb, p, s, h;
    logic [31:0] r;
    logic [15:0] ah, bh, ch;
    bit ua, ub;
    int sh;
    ua = (v.sm == 2'd1) || (v.sm == 2'd2);
    ub = (v.sm == 2'd1);
    r  = '0;
    if (v.wide) begin
      pa = ua ? longint'(v.a[15:0]) : longint'($signed(v.a[15:0]));
      pb = ub ? longint'(v.b[15:0]) : longint'($signed(v.b[15:0]));
      p  = pa * pb;
      return p[31:0];
    end
    for (int l = 0; l < 2; l++) begin
      ah = v.a[16*l +: 16];
      bh = v.b[16*l +: 16];
      ch = v.c[16*l +: 16];
      pa = ua ? longint'(ah) : longint'($signed(ah));
      pb = ub ? longint'(bh) : longint'($signed(bh));
      p  = pa * pb;
      sh = ub ? 16 : 15;
      if (v.rnd) p = p + (longint'(1) << (sh - 1));
      s = p >>> sh;
      h = ub ? longint'(ch) : longint'($signed(ch));
      if (v.am == 2'd1) s = s + h;
      else if (v.am == 2'd2) s = s - h;
      if (v.sat) begin
        if (ub) begin
          if (s > 65535) s = 65535;
          if (s < 0) s = 0;
        end else begin
          if (s > 32767) s = 32767;
          if (s < -32768) s = -32768;
        end
      end
      r[16*l +: 16] = s[15:0];
    end
    return r;
  endfunction

  function automatic string tag_of(input vec_t v);
    if (v.wide) return "R7";
    if (v.am == 2'd1 || v.am == 2'd2) return "R5";
    if (v.sat) return "R6";
    if (v.sm == 2'd1) return "R3";
    if (v.sm == 2'd2) return "R4";
    if (v.rnd) return "R2";
    return "R1";
  endfunction

  function automatic vec_t mk(input logic [31:0] a, input logic [31:0] b,
                              input logic [31:0] c, input logic [1:0] sm,
                              input logic [1:0] am, input logic rnd,
                              input logic sat, input logic wide);
    vec_t v;
    v.a = a; v.b = b; v.c = c; v.sm = sm; v.am = am;
    v.rnd = rnd; v.sat = sat; v.wide = wide;
    return v;
  endfunction

  function automatic logic [15:0] pick_half();
    case ($urandom_range(0, 5))
      0: return 16'h8000;
      1: return 16'h7FFF;
      2: return 16'hFFFF;
      3: return 16'h0000;
      default: return 16'($urandom);
    endcase
  endfunction

  function automatic vec_t rand_vec();
    vec_t v;
    v.a = {pick_half(), pick_half()};
    v.b = {pick_half(), pick_half()};
    v.c = {pick_half(), pick_half()};
    v.sm = 2'($urandom_range(0, 3));
    v.am = 2'($urandom_range(0, 3));
    v.rnd = 1'($urandom_range(0, 1));
    v.sat = 1'($urandom_range(0, 1));
    v.wide = ($urandom_range(0, 4) == 0);
    return v;
  endfunction

  task automatic drive(input vec_t v);
    op_a = v.a; op_b = v.b; acc_in = v.c;
    sgn_sel = v.sm; acc_sel = v.am;
    rnd_en = v.rnd; sat_en = v.sat; wide_en = v.wide;
  endtask

  vec_t        dir[$];
  logic [31:0] exp_q[$];
  string       tag_q[$];

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    vec_t        cur;
    logic [31:0] e, prev_res;
    string       t;
    int          idx, total, occ;
    bit          hold, stall_prev, fire_in, fire_out;

    // Directed beats: the first one also serves the latency check.
    dir.push_back(mk(32'h0180_0180, 32'h0180_0180, 0, 2'd0, 2'd0, 0, 0, 0)); // R1 -> 0x0004
    dir.push_back(mk(32'h0180_0180, 32'h0180_0180, 0, 2'd0, 2'd0, 1, 0, 0)); // R2 -> 0x0005
    dir.push_back(mk(32'h8000_8000, 32'h8000_8000, 0, 2'd0, 2'd0, 0, 1, 0)); // R6 clamp
    dir.push_back(mk(32'h8000_8000, 32'h8000_8000, 0, 2'd0, 2'd0, 0, 0, 0)); // R6 wrap
    dir.push_back(mk(32'hFFFF_FFFE, 32'hFFFF_0003, 0, 2'd1, 2'd0, 1, 0, 0)); // R3
    dir.push_back(mk(32'hC000_C000, 32'hC000_4000, 0, 2'd2, 2'd0, 0, 0, 0)); // R4
    dir.push_back(mk(32'h4000_4000, 32'h7FFF_7FFF, 32'h7000_0100, 2'd0, 2'd1, 0, 1, 0)); // R5/R6
    dir.push_back(mk(32'h4000_4000, 32'h7FFF_7FFF, 32'h7000_0100, 2'd0, 2'd2, 0, 0, 0)); // R5 sub
    dir.push_back(mk(32'h1234_5678, 32'h2222_3333, 32'h1111_1111, 2'd0, 2'd3, 0, 0, 0)); // R5 code 3
    dir.push_back(mk(32'hFFFF_F000, 32'hFFFF_8000, 32'h0001_FFFF, 2'd1, 2'd1, 0, 1, 0)); // R6 unsigned
    dir.push_back(mk(32'h0000_FFFF, 32'h0000_0002, 0, 2'd0, 2'd0, 0, 0, 1));           // R7 signed
    dir.push_back(mk(32'h0000_FFFF, 32'h0000_0002, 0, 2'd1, 2'd0, 0, 0, 1));           // R7 unsigned
    dir.push_back(mk(32'h0000_FFFF, 32'h0000_FFFF, 32'hFFFF_FFFF, 2'd2, 2'd2, 1, 1, 1)); // R7 ignores
    dir.push_back(mk(32'h8001_0180, 32'h7FFF_0180, 0, 2'd3, 2'd0, 0, 0, 0));           // R1 code 3

    // R10: state under reset.
    repeat (3) @(negedge clk);
    check(!out_valid, "R10", "out_valid in reset", {31'b0, out_valid}, 32'h0);
    check(in_ready, "R10", "in_ready in reset", {31'b0, in_ready}, 32'h1);
    rst_n = 1'b1;

    // R8: single beat into an empty block.
    @(negedge clk);
    drive(dir[0]);
    in_valid  = 1'b1;
    out_ready = 1'b1;
    #1;
    check(in_ready, "R8", "in_ready when empty", {31'b0, in_ready}, 32'h1);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check(!out_valid, "R8", "out_valid one edge after accept", {31'b0, out_valid}, 32'h0);
    @(negedge clk);
    #1;
    check(out_valid, "R8", "out_valid two edges after accept", {31'b0, out_valid}, 32'h1);
    check(result == 32'h0004_0004, "R1", "0x0180 squared truncated", result, 32'h0004_0004);

    // Streaming phase with gaps and back-pressure.
    total = dir.size() + NRAND;
    idx = 1; hold = 0; occ = 0; stall_prev = 0; prev_res = '0;
    while (idx < total || occ != 0 || hold) begin
      @(negedge clk);
      if (idx < dir.size() + 60) out_ready = 1'b1;
      else if ((idx % 50) < 12) out_ready = ($urandom_range(0, 3) == 0);
      else out_ready = ($urandom_range(0, 3) != 0);
      if (!hold) begin
        if (idx < total && $urandom_range(0, 4) != 0) begin
          cur = (idx < dir.size()) ? dir[idx] : rand_vec();
          drive(cur);
          in_valid = 1'b1;
          hold = 1;
        end else begin
          in_valid = 1'b0;
        end
      end
      #1;
      if (stall_prev)
        check(out_valid && result == prev_res, "R9", "held result under stall", result, prev_res);
      check(in_ready == !(occ == 2 && !out_ready), "R9", "in_ready vs occupancy",
            {31'b0, in_ready}, {31'b0, !(occ == 2 && !out_ready)});
      fire_out = out_valid && out_ready;
      fire_in  = in_valid && in_ready;
      if (out_valid && occ == 0)
        check(0, "R8", "out_valid with nothing in flight", 32'h1, 32'h0);
      if (fire_out && exp_q.size() != 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(result == e, t, "lane result", result, e);
      end
      if (fire_in) begin
        exp_q.push_back(model(cur));
        tag_q.push_back(tag_of(cur));
        idx++;
        hold = 0;
      end
      occ = occ + (fire_in ? 1 : 0) - ((fire_out && occ != 0) ? 1 : 0);
      stall_prev = out_valid && !out_ready;
      prev_res   = result;
    end
    in_valid = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule